// File: doc/BRIEF.md
# Cache ECC Injection Controller

This block sits beside a set-associative instruction cache. It holds the software-visible controls for ECC checking and runs a small sequencer that plants a poisoned entry in the cache arrays on request. Software sets an enable bit that drives the ECC check enable of the cache pipeline. It writes a physical address into an address register. It then writes a control word that chooses the target array (tag or data) and sets the start bit. The block first screens the request. An accepted request goes through four steps: read the tags of the addressed set, look for a way whose tag matches, write a poisoned entry into that way of the chosen array, and report the outcome in read-only status and error fields.

While the sequencer runs, it owns the tag read port, the tag write port and the data write port of the arrays, and the normal pipeline is stalled off them. When the sequencer is idle, the pipeline ports pass straight through. Register access uses a plain single-cycle write strobe with a combinational read path, decoded within a 128-byte window at a parameterised base address.

Top module: `ecc_inj_ctrl`

## Requirements
- R1: After reset the control word and the address register both read 0. This means enable 0, target 0, status 0 (idle) and error 0. The ECC check enable output is 0.
- R2: The control word is at window offset 0x00. Its bit 0 is enable, bit 1 is the start bit (always reads 0), bits 3:2 are the target, bits 6:4 are the status and bits 9:7 are the error code. Bits 63:10 read 0. The address register is at offset 0x08 and keeps the low PADDR_W bits, with the upper bits reading 0. Any other offset, and any address outside the window, reads 0 and ignores writes. The ECC check enable output follows bit 0 of the control word.
- R3: Writing the control word with bit 1 set and bit 0 clear gives status 7 with error 0. This holds whatever target is written, and no array access follows.
- R4: Writing the control word with bit 1 set, bit 0 set and target 1 or 3 gives status 7 with error 1, and no array access follows.
- R5: Writing the control word with bit 1 set, bit 0 set and target 0 or 2 makes the status read 1 (working) from the next cycle on. It also raises a tag read request for set paddr[OFFSET_W+SET_W-1:OFFSET_W], and that request and its set stay stable until the ready handshake.
- R6: If the tag response shows no valid way whose tag equals paddr[PADDR_W-1:OFFSET_W+SET_W], the status becomes 7 with error 2 and no write is issued.
- R7: On a hit with target 0, exactly one tag write is issued. It goes to the lowest-numbered hit way of the addressed set, carries the address tag with poison set, and the status then becomes 2 (injected).
- R8: On a hit with target 2, exactly one data write with poison set is issued to the lowest-numbered hit way of the addressed set, and the status then becomes 2.
- R9: While the status is working, the pipeline sees tag read ready low and none of its requests reach the arrays. While the sequencer is idle, every pipeline port passes to the arrays unchanged and the tag read ready returns to the pipeline.
- R10: A write of 1 to the start bit while the status is working is ignored: the status stays working and the running injection finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | BUS_AW | Register byte address |
| bus_wdata | input | 64 | Register write data |
| bus_rdata | output | 64 | Register read data for bus_addr |
| ecc_check_en | output | 1 | ECC check enable to the pipeline |
| pipe_tag_rd_valid | input | 1 | Pipeline tag read request |
| pipe_tag_rd_set | input | SET_W | Pipeline tag read set |
| pipe_tag_rd_ready | output | 1 | Tag read ready to the pipeline |
| pipe_tag_wr_valid | input | 1 | Pipeline tag write |
| pipe_tag_wr_set | input | SET_W | Pipeline tag write set |
| pipe_tag_wr_way | input | WAY_W | Pipeline tag write way |
| pipe_tag_wr_tag | input | TAG_W | Pipeline tag write value |
| pipe_tag_wr_poison | input | 1 | Pipeline tag write poison |
| pipe_data_wr_valid | input | 1 | Pipeline data write |
| pipe_data_wr_set | input | SET_W | Pipeline data write set |
| pipe_data_wr_way | input | WAY_W | Pipeline data write way |
| pipe_data_wr_data | input | DATA_W | Pipeline data write value |
| pipe_data_wr_poison | input | 1 | Pipeline data write poison |
| arr_tag_rd_valid | output | 1 | Tag array read request |
| arr_tag_rd_set | output | SET_W | Tag array read set |
| arr_tag_rd_ready | input | 1 | Tag array read ready |
| arr_tag_rsp_valid | input | 1 | Tag array read response valid |
| arr_tag_rsp_tags | input | WAYS*TAG_W | Tags of all ways, way 0 in the low bits |
| arr_tag_rsp_vld | input | WAYS | Valid bit of each way |
| arr_tag_wr_valid | output | 1 | Tag array write |
| arr_tag_wr_set | output | SET_W | Tag array write set |
| arr_tag_wr_way | output | WAY_W | Tag array write way |
| arr_tag_wr_tag | output | TAG_W | Tag array write value |
| arr_tag_wr_poison | output | 1 | Tag array write poison |
| arr_data_wr_valid | output | 1 | Data array write |
| arr_data_wr_set | output | SET_W | Data array write set |
| arr_data_wr_way | output | WAY_W | Data array write way |
| arr_data_wr_data | output | DATA_W | Data array write value |
| arr_data_wr_poison | output | 1 | Data array write poison |

## Verification
The hardest case to reach is pipeline traffic arriving while the sequencer holds the arrays. A second start write landing in the middle of an injection is just as hard. The bench models the tag array itself. It stretches the read handshake and the response delay by random amounts, and it drives random pipeline reads and unpoisoned writes in every cycle of a run, so that any leak shows up as an unpoisoned write or a stray read while the status still reads working. Random tag sets are built with zero, one or two matching ways to cover misses, lowest-way selection and both targets. In some runs a repeat start write is issued during the read phase.

// File: rtl/ecc_inj_pkg.sv
// Shared encodings of the ECC injection controller.
// Assumes: the status, error and target codes are software-visible and must not change.
package ecc_inj_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_RD_REQ,
        SEQ_RD_RSP,
        SEQ_WR_META,
        SEQ_WR_DATA
    } seq_state_t;

    localparam logic [2:0] ST_IDLE     = 3'd0;
    localparam logic [2:0] ST_WORKING  = 3'd1;
    localparam logic [2:0] ST_INJECTED = 3'd2;
    localparam logic [2:0] ST_ERROR    = 3'd7;

    localparam logic [2:0] ER_DISABLED   = 3'd0;
    localparam logic [2:0] ER_BAD_TARGET = 3'd1;
    localparam logic [2:0] ER_MISS       = 3'd2;

    localparam int WIN_BYTES = 128;

endpackage

// File: rtl/ecc_inj_regs.sv
// Register window: control word and injection address.
// Decodes a WIN_BYTES window at BASE_ADDR, which must be aligned to the window size.
// Produces a one-cycle start request that carries the enable and target of the same write.
module ecc_inj_regs
    import ecc_inj_pkg::*;
#(
    parameter int                BUS_AW    = 32,
    parameter logic [BUS_AW-1:0] BASE_ADDR = 32'h3802_2080,
    parameter int                PADDR_W   = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [63:0]        bus_wdata,
    output logic [63:0]        bus_rdata,
    input  logic [2:0]         status,
    input  logic [2:0]         err,
    output logic               chk_en,
    output logic [PADDR_W-1:0] paddr,
    output logic               inj_req,
    output logic               req_en,
    output logic [1:0]         req_target
);
    localparam int WIN_LSB = $clog2(WIN_BYTES);

    logic             in_win;
    logic             sel_ctrl;
    logic             sel_addr;
    logic [1:0]       tgt_q;
    logic             unused_wdata;

    // Window and offset decode.
    always_comb begin
        in_win   = (bus_addr[BUS_AW-1:WIN_LSB] == BASE_ADDR[BUS_AW-1:WIN_LSB]);
        sel_ctrl = in_win && (bus_addr[WIN_LSB-1:0] == WIN_LSB'(0));
        sel_addr = in_win && (bus_addr[WIN_LSB-1:0] == WIN_LSB'(8));
    end

    // Writable fields of both registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_en <= 1'b0;
            tgt_q  <= 2'd0;
            paddr  <= '0;
        end else if (bus_we) begin
            if (sel_ctrl) begin
                chk_en <= bus_wdata[0];
                tgt_q  <= bus_wdata[3:2];
            end
            if (sel_addr) begin
                paddr <= bus_wdata[PADDR_W-1:0];
            end
        end
    end

    // Start request uses the values carried by the same write.
    always_comb begin
        inj_req    = bus_we && sel_ctrl && bus_wdata[1];
        req_en     = bus_wdata[0];
        req_target = bus_wdata[3:2];
    end

    // Read mux; the start bit and unmapped bits read as zero.
    always_comb begin
        bus_rdata = 64'd0;
        if (sel_ctrl) begin
            bus_rdata = {54'd0, err, status, tgt_q, 1'b0, chk_en};
        end else if (sel_addr) begin
            bus_rdata = {{(64-PADDR_W){1'b0}}, paddr};
        end
    end

    assign unused_wdata = ^bus_wdata[63:PADDR_W];

endmodule

// File: rtl/ecc_inj_seq.sv
// Injection sequencer: screens a start request, reads the set's tags, checks for a hit,
// and writes one poisoned entry into the lowest hit way of the chosen array.
// Assumes the arrays accept a write in the cycle it is presented.
module ecc_inj_seq
    import ecc_inj_pkg::*;
#(
    parameter int PADDR_W  = 48,
    parameter int OFFSET_W = 6,
    parameter int SET_W    = 8,
    parameter int WAYS     = 4,
    parameter int DATA_W   = 64,
    localparam int TAG_W   = PADDR_W - OFFSET_W - SET_W,
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inj_req,
    input  logic               req_en,
    input  logic [1:0]         req_target,
    input  logic [PADDR_W-1:0] paddr,
    input  logic               rd_ready,
    input  logic               rsp_valid,
    input  logic [WAYS*TAG_W-1:0] rsp_tags,
    input  logic [WAYS-1:0]    rsp_vld,
    output logic               busy,
    output logic [2:0]         status,
    output logic [2:0]         err,
    output logic               rd_valid,
    output logic [SET_W-1:0]   op_set,
    output logic               tag_wr_valid,
    output logic               data_wr_valid,
    output logic [WAY_W-1:0]   op_way,
    output logic [TAG_W-1:0]   op_tag,
    output logic [DATA_W-1:0]  op_data
);
    seq_state_t       state;
    logic             to_data;
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic             unused_offset;

    // Lowest-index way whose valid tag matches the captured tag.
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (rsp_vld[w] && (rsp_tags[w*TAG_W +: TAG_W] == op_tag)) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    // Sequencer state, captured request and software-visible outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            status  <= ST_IDLE;
            err     <= ER_DISABLED;
            op_set  <= '0;
            op_tag  <= '0;
            op_way  <= '0;
            to_data <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (inj_req) begin
                        if (!req_en) begin
                            status <= ST_ERROR;
                            err    <= ER_DISABLED;
                        end else if (req_target[0]) begin
                            status <= ST_ERROR;
                            err    <= ER_BAD_TARGET;
                        end else begin
                            status  <= ST_WORKING;
                            state   <= SEQ_RD_REQ;
                            op_set  <= paddr[OFFSET_W +: SET_W];
                            op_tag  <= paddr[PADDR_W-1 -: TAG_W];
                            to_data <= req_target[1];
                        end
                    end
                end
                SEQ_RD_REQ: begin
                    if (rd_ready) state <= SEQ_RD_RSP;
                end
                SEQ_RD_RSP: begin
                    if (rsp_valid) begin
                        if (hit) begin
                            op_way <= hit_way;
                            state  <= to_data ? SEQ_WR_DATA : SEQ_WR_META;
                        end else begin
                            state  <= SEQ_IDLE;
                            status <= ST_ERROR;
                            err    <= ER_MISS;
                        end
                    end
                end
                default: begin
                    state  <= SEQ_IDLE;
                    status <= ST_INJECTED;
                end
            endcase
        end
    end

    // Array-side strobes decoded from the state.
    always_comb begin
        busy          = (state != SEQ_IDLE);
        rd_valid      = (state == SEQ_RD_REQ);
        tag_wr_valid  = (state == SEQ_WR_META);
        data_wr_valid = (state == SEQ_WR_DATA);
        op_data       = '0;
    end

    assign unused_offset = ^paddr[OFFSET_W-1:0];

    // R5: the read request and its set hold until the handshake.
    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(op_set));

    // R7: one tag write, then injected.
    assert_tag_wr_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tag_wr_valid |=> !tag_wr_valid && status == ST_INJECTED);

    // R8: one data write, then injected.
    assert_data_wr_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr_valid |=> !data_wr_valid && status == ST_INJECTED);

    // R3: disabled start reports error 0 regardless of target.
    assert_disabled_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inj_req && !busy && !req_en |=> status == ST_ERROR && err == ER_DISABLED && !rd_valid);

    // R10: a start while the read is pending leaves the run working.
    assert_restart_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        inj_req && rd_valid |=> status == ST_WORKING);

endmodule

// File: rtl/ecc_inj_mux.sv
// Array port steering: pipeline ports pass through when idle; the sequencer owns them when busy.
// Assumes the sequencer's writes are always poisoned.
module ecc_inj_mux #(
    parameter int SET_W  = 8,
    parameter int WAY_W  = 2,
    parameter int TAG_W  = 34,
    parameter int DATA_W = 64
) (
    input  logic              busy,
    input  logic              seq_rd_valid,
    input  logic              seq_tag_wr_valid,
    input  logic              seq_data_wr_valid,
    input  logic [SET_W-1:0]  seq_set,
    input  logic [WAY_W-1:0]  seq_way,
    input  logic [TAG_W-1:0]  seq_tag,
    input  logic [DATA_W-1:0] seq_data,
    input  logic              pipe_tag_rd_valid,
    input  logic [SET_W-1:0]  pipe_tag_rd_set,
    output logic              pipe_tag_rd_ready,
    input  logic              pipe_tag_wr_valid,
    input  logic [SET_W-1:0]  pipe_tag_wr_set,
    input  logic [WAY_W-1:0]  pipe_tag_wr_way,
    input  logic [TAG_W-1:0]  pipe_tag_wr_tag,
    input  logic              pipe_tag_wr_poison,
    input  logic              pipe_data_wr_valid,
    input  logic [SET_W-1:0]  pipe_data_wr_set,
    input  logic [WAY_W-1:0]  pipe_data_wr_way,
    input  logic [DATA_W-1:0] pipe_data_wr_data,
    input  logic              pipe_data_wr_poison,
    output logic              arr_tag_rd_valid,
    output logic [SET_W-1:0]  arr_tag_rd_set,
    input  logic              arr_tag_rd_ready,
    output logic              arr_tag_wr_valid,
    output logic [SET_W-1:0]  arr_tag_wr_set,
    output logic [WAY_W-1:0]  arr_tag_wr_way,
    output logic [TAG_W-1:0]  arr_tag_wr_tag,
    output logic              arr_tag_wr_poison,
    output logic              arr_data_wr_valid,
    output logic [SET_W-1:0]  arr_data_wr_set,
    output logic [WAY_W-1:0]  arr_data_wr_way,
    output logic [DATA_W-1:0] arr_data_wr_data,
    output logic              arr_data_wr_poison
);
    // Select the owner of every array port.
    always_comb begin
        if (busy) begin
            arr_tag_rd_valid   = seq_rd_valid;
            arr_tag_rd_set     = seq_set;
            pipe_tag_rd_ready  = 1'b0;
            arr_tag_wr_valid   = seq_tag_wr_valid;
            arr_tag_wr_set     = seq_set;
            arr_tag_wr_way     = seq_way;
            arr_tag_wr_tag     = seq_tag;
            arr_tag_wr_poison  = 1'b1;
            arr_data_wr_valid  = seq_data_wr_valid;
            arr_data_wr_set    = seq_set;
            arr_data_wr_way    = seq_way;
            arr_data_wr_data   = seq_data;
            arr_data_wr_poison = 1'b1;
        end else begin
            arr_tag_rd_valid   = pipe_tag_rd_valid;
            arr_tag_rd_set     = pipe_tag_rd_set;
            pipe_tag_rd_ready  = arr_tag_rd_ready;
            arr_tag_wr_valid   = pipe_tag_wr_valid;
            arr_tag_wr_set     = pipe_tag_wr_set;
            arr_tag_wr_way     = pipe_tag_wr_way;
            arr_tag_wr_tag     = pipe_tag_wr_tag;
            arr_tag_wr_poison  = pipe_tag_wr_poison;
            arr_data_wr_valid  = pipe_data_wr_valid;
            arr_data_wr_set    = pipe_data_wr_set;
            arr_data_wr_way    = pipe_data_wr_way;
            arr_data_wr_data   = pipe_data_wr_data;
            arr_data_wr_poison = pipe_data_wr_poison;
        end
    end

endmodule

// File: rtl/ecc_inj_ctrl.sv
// Top of the cache ECC injection controller: register window, sequencer and port steering.
// Assumes a single-cycle register bus with combinational read data.
module ecc_inj_ctrl
    import ecc_inj_pkg::*;
#(
    parameter int                BUS_AW    = 32,
    parameter logic [BUS_AW-1:0] BASE_ADDR = 32'h3802_2080,
    parameter int                PADDR_W   = 48,
    parameter int                OFFSET_W  = 6,
    parameter int                SET_W     = 8,
    parameter int                WAYS      = 4,
    parameter int                DATA_W    = 64,
    localparam int               TAG_W     = PADDR_W - OFFSET_W - SET_W,
    localparam int               WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [BUS_AW-1:0]     bus_addr,
    input  logic [63:0]           bus_wdata,
    output logic [63:0]           bus_rdata,
    output logic                  ecc_check_en,
    input  logic                  pipe_tag_rd_valid,
    input  logic [SET_W-1:0]      pipe_tag_rd_set,
    output logic                  pipe_tag_rd_ready,
    input  logic                  pipe_tag_wr_valid,
    input  logic [SET_W-1:0]      pipe_tag_wr_set,
    input  logic [WAY_W-1:0]      pipe_tag_wr_way,
    input  logic [TAG_W-1:0]      pipe_tag_wr_tag,
    input  logic                  pipe_tag_wr_poison,
    input  logic                  pipe_data_wr_valid,
    input  logic [SET_W-1:0]      pipe_data_wr_set,
    input  logic [WAY_W-1:0]      pipe_data_wr_way,
    input  logic [DATA_W-1:0]     pipe_data_wr_data,
    input  logic                  pipe_data_wr_poison,
    output logic                  arr_tag_rd_valid,
    output logic [SET_W-1:0]      arr_tag_rd_set,
    input  logic                  arr_tag_rd_ready,
    input  logic                  arr_tag_rsp_valid,
    input  logic [WAYS*TAG_W-1:0] arr_tag_rsp_tags,
    input  logic [WAYS-1:0]       arr_tag_rsp_vld,
    output logic                  arr_tag_wr_valid,
    output logic [SET_W-1:0]      arr_tag_wr_set,
    output logic [WAY_W-1:0]      arr_tag_wr_way,
    output logic [TAG_W-1:0]      arr_tag_wr_tag,
    output logic                  arr_tag_wr_poison,
    output logic                  arr_data_wr_valid,
    output logic [SET_W-1:0]      arr_data_wr_set,
    output logic [WAY_W-1:0]      arr_data_wr_way,
    output logic [DATA_W-1:0]     arr_data_wr_data,
    output logic                  arr_data_wr_poison
);
    logic [2:0]         status;
    logic [2:0]         err;
    logic [PADDR_W-1:0] paddr;
    logic               inj_req;
    logic               req_en;
    logic [1:0]         req_target;
    logic               busy;
    logic               seq_rd_valid;
    logic               seq_tag_wr_valid;
    logic               seq_data_wr_valid;
    logic [SET_W-1:0]   seq_set;
    logic [WAY_W-1:0]   seq_way;
    logic [TAG_W-1:0]   seq_tag;
    logic [DATA_W-1:0]  seq_data;

    ecc_inj_regs #(
        .BUS_AW(BUS_AW), .BASE_ADDR(BASE_ADDR), .PADDR_W(PADDR_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status(status), .err(err),
        .chk_en(ecc_check_en), .paddr(paddr), .inj_req(inj_req), .req_en(req_en),
        .req_target(req_target)
    );

    ecc_inj_seq #(
        .PADDR_W(PADDR_W), .OFFSET_W(OFFSET_W), .SET_W(SET_W), .WAYS(WAYS), .DATA_W(DATA_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .inj_req(inj_req), .req_en(req_en),
        .req_target(req_target), .paddr(paddr), .rd_ready(arr_tag_rd_ready),
        .rsp_valid(arr_tag_rsp_valid), .rsp_tags(arr_tag_rsp_tags), .rsp_vld(arr_tag_rsp_vld),
        .busy(busy), .status(status), .err(err), .rd_valid(seq_rd_valid), .op_set(seq_set),
        .tag_wr_valid(seq_tag_wr_valid), .data_wr_valid(seq_data_wr_valid),
        .op_way(seq_way), .op_tag(seq_tag), .op_data(seq_data)
    );

    ecc_inj_mux #(
        .SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) mux_i (
        .busy(busy), .seq_rd_valid(seq_rd_valid), .seq_tag_wr_valid(seq_tag_wr_valid),
        .seq_data_wr_valid(seq_data_wr_valid), .seq_set(seq_set), .seq_way(seq_way),
        .seq_tag(seq_tag), .seq_data(seq_data),
        .pipe_tag_rd_valid(pipe_tag_rd_valid), .pipe_tag_rd_set(pipe_tag_rd_set),
        .pipe_tag_rd_ready(pipe_tag_rd_ready), .pipe_tag_wr_valid(pipe_tag_wr_valid),
        .pipe_tag_wr_set(pipe_tag_wr_set), .pipe_tag_wr_way(pipe_tag_wr_way),
        .pipe_tag_wr_tag(pipe_tag_wr_tag), .pipe_tag_wr_poison(pipe_tag_wr_poison),
        .pipe_data_wr_valid(pipe_data_wr_valid), .pipe_data_wr_set(pipe_data_wr_set),
        .pipe_data_wr_way(pipe_data_wr_way), .pipe_data_wr_data(pipe_data_wr_data),
        .pipe_data_wr_poison(pipe_data_wr_poison),
        .arr_tag_rd_valid(arr_tag_rd_valid), .arr_tag_rd_set(arr_tag_rd_set),
        .arr_tag_rd_ready(arr_tag_rd_ready), .arr_tag_wr_valid(arr_tag_wr_valid),
        .arr_tag_wr_set(arr_tag_wr_set), .arr_tag_wr_way(arr_tag_wr_way),
        .arr_tag_wr_tag(arr_tag_wr_tag), .arr_tag_wr_poison(arr_tag_wr_poison),
        .arr_data_wr_valid(arr_data_wr_valid), .arr_data_wr_set(arr_data_wr_set),
        .arr_data_wr_way(arr_data_wr_way), .arr_data_wr_data(arr_data_wr_data),
        .arr_data_wr_poison(arr_data_wr_poison)
    );

    // R9: no unpoisoned array write while the sequencer owns the ports.
    assert_no_pipe_leak_R9: assert property (@(posedge clk) disable iff (!rst_n)
        status == ST_WORKING && (arr_tag_wr_valid || arr_data_wr_valid) |->
        (arr_tag_wr_valid ? arr_tag_wr_poison : arr_data_wr_poison));

endmodule

// File: tb/ecc_inj_ctrl_tb_top.sv
// Self-checking bench: random injections against a modelled tag array plus directed register cases.
`timescale 1ns/1ps
module ecc_inj_ctrl_tb_top;
    localparam int CLK_NS   = 20;
    localparam int BUS_AW   = 32;
    localparam logic [31:0] BASE = 32'h3802_2080;
    localparam int PADDR_W  = 48;
    localparam int OFFSET_W = 6;
    localparam int SET_W    = 8;
    localparam int WAYS     = 4;
    localparam int DATA_W   = 64;
    localparam int TAG_W    = PADDR_W - OFFSET_W - SET_W;
    localparam int WAY_W    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic [BUS_AW-1:0] bus_addr = BASE;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic ecc_check_en;
    logic pipe_tag_rd_valid = 1'b0;
    logic [SET_W-1:0] pipe_tag_rd_set = '0;
    logic pipe_tag_rd_ready;
    logic pipe_tag_wr_valid = 1'b0;
    logic [SET_W-1:0] pipe_tag_wr_set = '0;
    logic [WAY_W-1:0] pipe_tag_wr_way = '0;
    logic [TAG_W-1:0] pipe_tag_wr_tag = '0;
    logic pipe_tag_wr_poison = 1'b0;
    logic pipe_data_wr_valid = 1'b0;
    logic [SET_W-1:0] pipe_data_wr_set = '0;
    logic [WAY_W-1:0] pipe_data_wr_way = '0;
    logic [DATA_W-1:0] pipe_data_wr_data = '0;
    logic pipe_data_wr_poison = 1'b0;
    logic arr_tag_rd_valid;
    logic [SET_W-1:0] arr_tag_rd_set;
    logic arr_tag_rd_ready = 1'b0;
    logic arr_tag_rsp_valid = 1'b0;
    logic [WAYS*TAG_W-1:0] arr_tag_rsp_tags = '0;
    logic [WAYS-1:0] arr_tag_rsp_vld = '0;
    logic arr_tag_wr_valid;
    logic [SET_W-1:0] arr_tag_wr_set;
    logic [WAY_W-1:0] arr_tag_wr_way;
    logic [TAG_W-1:0] arr_tag_wr_tag;
    logic arr_tag_wr_poison;
    logic arr_data_wr_valid;
    logic [SET_W-1:0] arr_data_wr_set;
    logic [WAY_W-1:0] arr_data_wr_way;
    logic [DATA_W-1:0] arr_data_wr_data;
    logic arr_data_wr_poison;

    int n_chk = 0;
    int n_err = 0;

    ecc_inj_ctrl dut_i (.*);

    always #(CLK_NS/2) clk = ~clk;

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] off, input logic [63:0] data);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = BASE + 32'(off); bus_wdata = data;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = BASE;
    endtask

    task automatic bus_read(input logic [31:0] addr, output logic [63:0] data);
        bus_addr = addr;
        #1;
        data = bus_rdata;
        bus_addr = BASE;
        #1;
    endtask

    function automatic logic [63:0] ctrl_word(input bit en, input bit go, input logic [1:0] tgt);
        return {58'd0, tgt, go, en};
    endfunction

    // Expected hit way: lowest valid way with equal tag, WAYS on a miss.
    function automatic int exp_way(input logic [WAYS*TAG_W-1:0] tags, input logic [WAYS-1:0] vld,
                                   input logic [TAG_W-1:0] tag);
        for (int w = 0; w < WAYS; w++)
            if (vld[w] && tags[w*TAG_W +: TAG_W] == tag) return w;
        return WAYS;
    endfunction

    task automatic drive_pipe_random();
        pipe_tag_rd_valid   = 1'($urandom);
        pipe_tag_rd_set     = SET_W'($urandom);
        pipe_tag_wr_valid   = 1'($urandom);
        pipe_tag_wr_set     = SET_W'($urandom);
        pipe_tag_wr_way     = WAY_W'($urandom);
        pipe_tag_wr_tag     = TAG_W'({$urandom, $urandom});
        pipe_tag_wr_poison  = 1'b0;
        pipe_data_wr_valid  = 1'($urandom);
        pipe_data_wr_set    = SET_W'($urandom);
        pipe_data_wr_way    = WAY_W'($urandom);
        pipe_data_wr_data   = {$urandom, $urandom};
        pipe_data_wr_poison = 1'b0;
    endtask

    // One accepted injection with a modelled tag array.
    task automatic run_inj(input logic [PADDR_W-1:0] pa, input logic [1:0] tgt,
                           input int hits, input bit restart);
        logic [SET_W-1:0] eset;
        logic [TAG_W-1:0] etag;
        logic [63:0] rd;
        int eway;
        int phase;
        int dly;
        int n_tag;
        int n_data;
        bit ign;
        eset = pa[OFFSET_W +: SET_W];
        etag = pa[PADDR_W-1 -: TAG_W];
        for (int w = 0; w < WAYS; w++) begin
            arr_tag_rsp_tags[w*TAG_W +: TAG_W] = TAG_W'({$urandom, $urandom});
            arr_tag_rsp_vld[w] = 1'($urandom);
        end
        for (int h = 0; h < hits; h++) begin
            int k;
            k = int'($urandom % WAYS);
            arr_tag_rsp_tags[k*TAG_W +: TAG_W] = etag;
            arr_tag_rsp_vld[k] = 1'b1;
        end
        eway = exp_way(arr_tag_rsp_tags, arr_tag_rsp_vld, etag);
        bus_write(8'h08, {16'd0, pa});
        bus_write(8'h00, ctrl_word(1'b1, 1'b1, tgt));
        bus_read(BASE, rd);
        chk(rd[6:4] == 3'd1, "R5 status working after start", 64'(rd[6:4]), 64'd1);
        phase = 0; dly = int'($urandom % 3); n_tag = 0; n_data = 0; ign = 1'b0;
        for (int cyc = 0; cyc < 80; cyc++) begin
            bus_we = 1'b0;
            bus_read(BASE, rd);
            if (ign) begin
                chk(rd[6:4] == 3'd1, "R10 restart ignored", 64'(rd[6:4]), 64'd1);
                ign = 1'b0;
            end
            if (rd[6:4] != 3'd1) break;
            if (arr_tag_wr_valid) begin
                n_tag++;
                chk(arr_tag_wr_poison && arr_tag_wr_set == eset && int'(arr_tag_wr_way) == eway
                    && arr_tag_wr_tag == etag, "R7 tag write fields",
                    {arr_tag_wr_poison, arr_tag_wr_set, arr_tag_wr_way, arr_tag_wr_tag},
                    {1'b1, eset, WAY_W'(eway), etag});
            end
            if (arr_data_wr_valid) begin
                n_data++;
                chk(arr_data_wr_poison && arr_data_wr_set == eset && int'(arr_data_wr_way) == eway,
                    "R8 data write fields",
                    {arr_data_wr_poison, arr_data_wr_set, arr_data_wr_way},
                    {1'b1, eset, WAY_W'(eway)});
            end
            chk(!pipe_tag_rd_ready, "R9 pipeline ready low while working", 64'(pipe_tag_rd_ready), 64'd0);
            case (phase)
                0: begin
                    chk(arr_tag_rd_valid && arr_tag_rd_set == eset, "R5 tag read request and set",
                        {arr_tag_rd_valid, arr_tag_rd_set}, {1'b1, eset});
                    arr_tag_rd_ready = 1'($urandom);
                    if (arr_tag_rd_ready) phase = 1;
                    else if (restart && !ign) begin
                        bus_we = 1'b1; bus_wdata = ctrl_word(1'b1, 1'b1, tgt); ign = 1'b1;
                        restart = 1'b0;
                    end
                end
                1: begin
                    arr_tag_rd_ready = 1'b0;
                    chk(!arr_tag_rd_valid, "R9 no pipeline read while working", 64'(arr_tag_rd_valid), 64'd0);
                    if (dly == 0) begin arr_tag_rsp_valid = 1'b1; phase = 2; end
                    else dly--;
                end
                default: arr_tag_rsp_valid = 1'b0;
            endcase
            drive_pipe_random();
            @(negedge clk);
        end
        bus_we = 1'b0; arr_tag_rd_ready = 1'b0; arr_tag_rsp_valid = 1'b0;
        pipe_tag_wr_valid = 1'b0; pipe_data_wr_valid = 1'b0; pipe_tag_rd_valid = 1'b0;
        bus_read(BASE, rd);
        if (eway == WAYS) begin
            chk(rd[9:4] == {3'd2, 3'd7}, "R6 miss reports error 2", 64'(rd[9:4]), 64'({3'd2, 3'd7}));
            chk(n_tag + n_data == 0, "R6 no write on miss", 64'(n_tag + n_data), 64'd0);
        end else begin
            chk(rd[6:4] == 3'd2, tgt[1] ? "R8 status injected" : "R7 status injected",
                64'(rd[6:4]), 64'd2);
            chk(n_tag == (tgt[1] ? 0 : 1) && n_data == (tgt[1] ? 1 : 0),
                tgt[1] ? "R8 exactly one data write" : "R7 exactly one tag write",
                64'({n_tag[15:0], n_data[15:0]}), 64'(tgt[1] ? 1 : 32'h10000));
        end
    endtask

    task automatic bad_start(input bit en, input logic [1:0] tgt, input logic [2:0] exp_err, input string req);
        logic [63:0] rd;
        bus_write(8'h00, ctrl_word(en, 1'b1, tgt));
        bus_read(BASE, rd);
        chk(rd[9:4] == {exp_err, 3'd7}, req, 64'(rd[9:4]), 64'({exp_err, 3'd7}));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(!arr_tag_rd_valid, {req, " no array read"}, 64'(arr_tag_rd_valid), 64'd0);
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_err++;
        $display("FAIL watchdog expired (R5 handshake hang) actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [63:0] rd;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        bus_read(BASE, rd);
        chk(rd == 64'd0, "R1 control word after reset", rd, 64'd0);
        bus_read(BASE + 32'd8, rd);
        chk(rd == 64'd0, "R1 address after reset", rd, 64'd0);
        chk(ecc_check_en == 1'b0, "R1 check enable after reset", 64'(ecc_check_en), 64'd0);

        // R2 register map, read-as-zero bits, and enable output
        bus_write(8'h00, ctrl_word(1'b1, 1'b0, 2'd2) | 64'hFFFF_FFFF_FFFF_FC00);
        bus_read(BASE, rd);
        chk(rd == 64'h9, "R2 WARL bits read zero", rd, 64'h9);
        chk(ecc_check_en == 1'b1, "R2 check enable follows bit 0", 64'(ecc_check_en), 64'd1);
        bus_write(8'h08, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_read(BASE + 32'd8, rd);
        chk(rd == 64'h0000_FFFF_FFFF_FFFF, "R2 address keeps low bits", rd, 64'h0000_FFFF_FFFF_FFFF);
        bus_write(8'h10, 64'h1234);
        bus_write(8'h80, 64'h0);
        bus_read(BASE + 32'h10, rd);
        chk(rd == 64'd0, "R2 unmapped offset reads zero", rd, 64'd0);
        bus_read(BASE + 32'h80, rd);
        chk(rd == 64'd0, "R2 outside window reads zero", rd, 64'd0);
        bus_read(BASE, rd);
        chk(rd == 64'h9, "R2 stray writes ignored", rd, 64'h9);
        bus_write(8'h00, ctrl_word(1'b0, 1'b0, 2'd0));
        chk(ecc_check_en == 1'b0, "R2 check enable cleared", 64'(ecc_check_en), 64'd0);

        // R3 and R4 screened starts; all-ones word also shows start bit reads 0
        bad_start(1'b0, 2'd1, 3'd0, "R3 disabled with reserved target");
        bad_start(1'b0, 2'd0, 3'd0, "R3 disabled");
        bad_start(1'b1, 2'd1, 3'd1, "R4 target 1");
        bad_start(1'b1, 2'd3, 3'd1, "R4 target 3");
        bus_write(8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_read(BASE, rd);
        chk(rd == 64'hFD, "R2 start bit reads zero", rd, 64'hFD);

        // R9 idle pass-through
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            drive_pipe_random();
            pipe_tag_wr_poison = 1'($urandom); pipe_data_wr_poison = 1'($urandom);
            arr_tag_rd_ready = 1'($urandom);
            #1;
            chk({arr_tag_rd_valid, arr_tag_rd_set, pipe_tag_rd_ready} ==
                {pipe_tag_rd_valid, pipe_tag_rd_set, arr_tag_rd_ready},
                "R9 idle read pass-through", {arr_tag_rd_valid, arr_tag_rd_set, pipe_tag_rd_ready},
                {pipe_tag_rd_valid, pipe_tag_rd_set, arr_tag_rd_ready});
            chk({arr_tag_wr_valid, arr_tag_wr_set, arr_tag_wr_way, arr_tag_wr_tag, arr_tag_wr_poison} ==
                {pipe_tag_wr_valid, pipe_tag_wr_set, pipe_tag_wr_way, pipe_tag_wr_tag, pipe_tag_wr_poison},
                "R9 idle tag write pass-through", 64'(arr_tag_wr_tag), 64'(pipe_tag_wr_tag));
            chk({arr_data_wr_valid, arr_data_wr_set, arr_data_wr_way, arr_data_wr_data, arr_data_wr_poison} ==
                {pipe_data_wr_valid, pipe_data_wr_set, pipe_data_wr_way, pipe_data_wr_data, pipe_data_wr_poison},
                "R9 idle data write pass-through", arr_data_wr_data, pipe_data_wr_data);
        end
        @(negedge clk);
        arr_tag_rd_ready = 1'b0;
        pipe_tag_rd_valid = 1'b0; pipe_tag_wr_valid = 1'b0; pipe_data_wr_valid = 1'b0;

        // Directed corner cases: lowest way wins, miss, restart during read
        run_inj({14'h1ABC, 34'd0} | 48'h0000_0000_3FC0, 2'd0, 2, 1'b1);
        run_inj(48'h0000_0000_0040, 2'd2, 0, 1'b0);
        run_inj(48'hFFFF_FFFF_FFFF, 2'd2, 1, 1'b1);

        // Random injections
        for (int n = 0; n < 40; n++) begin
            run_inj(PADDR_W'({$urandom, $urandom}), ($urandom % 2) ? 2'd2 : 2'd0,
                    int'($urandom % 3), 1'($urandom));
        end

        finish_run();
    end
endmodule